// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps the message-signalled interrupt state of one PCI-style function. That state is a table of per-vector message entries, a pending-bit array and the two writable bits of the function's message control word. Software reaches all three through one register port. The port takes aligned 32-bit and 64-bit reads and writes and selects a region with a two-bit code. Read data is combinational and is valid in the same cycle as the request. A write takes effect at the next clock edge.

Interrupt sources pulse a trigger input and give it a vector index. If the function is enabled and neither mask blocks the vector, the block queues a message request. A message request is the entry's 64-bit address and 32-bit data, sent on a valid/ready output. If a mask blocks the vector, the block sets the vector's pending bit and sends nothing. Once every mask on a pending vector has cleared, the block replays that vector automatically. All requests share the single output and leave it one at a time, lowest vector index first.

Top module: `msix_ctrl`

## Requirements
- R1: After reset, every table entry, every pending bit, the enable bit and the function mask read as zero, and `msg_valid` is low.
- R2: Table entry v begins at byte offset 16*v of region 0 (table). Its dwords are: address low at +0x0, address high at +0x4, message data at +0x8 and vector control at +0xC. A 32-bit access needs offset bits [1:0] = 0 and uses data bits [31:0].
- R3: A 64-bit table access needs offset bits [2:0] = 0. At +0x0 it carries {address high, address low}. At +0x8 it carries {vector control, message data}.
- R4: Only bit 0 of vector control, the per-vector mask, is stored. Every other vector control bit reads as zero.
- R5: Region 2 (control) accepts only a 32-bit access at offset 0. Bit 15 is the enable and bit 14 is the function mask, and both are writable. Bits 10:0 read NUM_VEC-1 and ignore writes. All other bits read zero.
- R6: A trigger on an unmasked vector, with the function mask clear and enable set, produces one message that carries that entry's {address high, address low} and data.
- R7: A trigger on a vector whose own mask or the function mask is set sets that vector's pending bit and produces no message.
- R8: When a vector's mask goes from 1 to 0 while the function mask is clear and its pending bit is set, the block sends that vector's message and clears its pending bit.
- R9: When the function mask goes from 1 to 0, the block sends a message for every pending vector whose own mask is clear, in ascending index order, one per accepted handshake. It clears their pending bits.
- R10: Region 1 (pending array) is word w at offset 8*w, and vector v sits at bit v%64 of word v/64. There are NUM_VEC/64+1 words. A 32-bit read at +0x0 gives bits 31:0 and at +0x4 gives bits 63:32. A 64-bit read at +0x0 gives the whole word. Writes to this region change nothing.
- R11: A misaligned access, a 64-bit control access, an index beyond the table or array, or region 3 is rejected. A rejected write changes nothing and a rejected read returns zero.
- R12: A vector whose 64-bit address is zero never produces a message. Its request is dropped and no pending bit is left behind.
- R13: While enable is clear, triggers are discarded. They produce no message and set no pending bit.
- R14: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| acc_region | input | 2 | 0 table, 1 pending array, 2 control, 3 none |
| acc_offset | input | OFF_W | Byte offset inside the region |
| acc_wdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| acc_rdata | output | 64 | Combinational read data, zero when rejected |
| trig_valid | input | 1 | Interrupt trigger pulse |
| trig_vec | input | IDX_W | Vector index of the trigger |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Some properties are checked on every cycle. These are: the message output holds under backpressure, no message ever carries a zero address, a message can start only while enabled, the reset state, and a misaligned read returns zero. The bench's scenarios are needed for everything that depends on the order of events. That covers pending capture under either mask, replay when the vector mask or the function mask clears, ascending drain order, the table and pending-array layouts, and the ignored pending-array writes. The read-only size field, discarding while disabled and the dropping of zero-address requests also rely on scenarios.

// File: rtl/msix_pkg.sv
package msix_pkg;

    typedef enum logic [1:0] {
        RG_TABLE = 2'd0,
        RG_PBA   = 2'd1,
        RG_CTRL  = 2'd2,
        RG_NONE  = 2'd3
    } region_e;

    typedef struct packed {
        logic [31:0] addr_lo;
        logic [31:0] addr_hi;
        logic [31:0] data;
        logic        mask;
    } vec_entry_t;

    localparam int ENTRY_BYTES = 16;
    localparam int PBA_BITS    = 64;

    // Alignment rule shared by table and pending-array accesses.
    function automatic logic access_aligned(logic wide, logic [2:0] low);
        return wide ? (low == 3'b000) : (low[1:0] == 2'b00);
    endfunction

    // Read view of one entry: dw is offset bits [3:2].
    function automatic logic [63:0] entry_read(vec_entry_t e, logic wide, logic [1:0] dw);
        logic [63:0] r;
        if (wide) begin
            r = dw[1] ? {31'b0, e.mask, e.data} : {e.addr_hi, e.addr_lo};
        end else begin
            case (dw)
                2'd0:    r = {32'b0, e.addr_lo};
                2'd1:    r = {32'b0, e.addr_hi};
                2'd2:    r = {32'b0, e.data};
                default: r = {63'b0, e.mask};
            endcase
        end
        return r;
    endfunction

    // Merge a write into one entry; reserved control bits are dropped.
    function automatic vec_entry_t entry_merge(vec_entry_t cur, logic wide, logic [1:0] dw,
                                               logic [63:0] wd);
        vec_entry_t n;
        n = cur;
        if (wide) begin
            if (!dw[1]) begin
                n.addr_lo = wd[31:0];
                n.addr_hi = wd[63:32];
            end else begin
                n.data = wd[31:0];
                n.mask = wd[32];
            end
        end else begin
            case (dw)
                2'd0:    n.addr_lo = wd[31:0];
                2'd1:    n.addr_hi = wd[31:0];
                2'd2:    n.data    = wd[31:0];
                default: n.mask    = wd[0];
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/msix_vec_store.sv
module msix_vec_store
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic                    wr_wide,
    input  logic [1:0]              wr_dw,
    input  logic [63:0]             wr_data,
    output vec_entry_t              entries [NUM_VEC],
    output logic [NUM_VEC-1:0]      vmask
);

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_ent
        vec_entry_t ent_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(v))) begin
                ent_q <= entry_merge(ent_q, wr_wide, wr_dw, wr_data);
            end
        end

        assign entries[v] = ent_q;
        assign vmask[v]   = ent_q.mask;
    end

endmodule

// File: rtl/msix_pend_ctrl.sv
module msix_pend_ctrl #(
    parameter int NUM_VEC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               fmask,
    input  logic [NUM_VEC-1:0] vmask,
    input  logic [NUM_VEC-1:0] trig_hit,
    input  logic [NUM_VEC-1:0] issue_clr,
    input  logic [NUM_VEC-1:0] issue_repend,
    output logic [NUM_VEC-1:0] req_q,
    output logic [NUM_VEC-1:0] pend_q
);

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_bit
        logic blocked;
        logic accept;
        logic replay;

        assign blocked = vmask[v] | fmask;
        assign accept  = trig_hit[v] & enable;
        // A pending vector becomes eligible only once both masks are clear;
        // pending bits are only ever set while masked, so this fires on the
        // clearing edge of whichever mask was last holding it.
        assign replay  = pend_q[v] & ~blocked;

        always_ff @(posedge clk) begin
            if (rst) begin
                req_q[v]  <= 1'b0;
                pend_q[v] <= 1'b0;
            end else begin
                req_q[v]  <= (req_q[v] & ~issue_clr[v]) | (accept & ~blocked) | replay;
                pend_q[v] <= (pend_q[v] & ~replay) | (accept & blocked) | issue_repend[v];
            end
        end
    end

endmodule

// File: rtl/msix_issue.sv
module msix_issue
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               fmask,
    input  logic [NUM_VEC-1:0] req_q,
    input  vec_entry_t         entries [NUM_VEC],
    output logic [NUM_VEC-1:0] issue_clr,
    output logic [NUM_VEC-1:0] issue_repend,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);

    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    vec_entry_t       pick_ent;
    logic             can_load;
    logic             go;
    logic             pick_blocked;
    logic             pick_zero;

    logic             valid_q;
    logic [63:0]      addr_q;
    logic [31:0]      data_q;

    // Lowest set request wins: the descending scan leaves the lowest index.
    always_comb begin
        pick_any = 1'b0;
        pick_idx = '0;
        pick_ent = '0;
        for (int v = NUM_VEC - 1; v >= 0; v--) begin
            if (req_q[v]) begin
                pick_any = 1'b1;
                pick_idx = IDX_W'(v);
                pick_ent = entries[v];
            end
        end
    end

    assign can_load     = enable && (!valid_q || msg_ready);
    assign go           = can_load && pick_any;
    assign pick_blocked = fmask | pick_ent.mask;
    assign pick_zero    = ({pick_ent.addr_hi, pick_ent.addr_lo} == 64'd0);

    always_comb begin
        issue_clr    = '0;
        issue_repend = '0;
        if (go) begin
            issue_clr[pick_idx] = 1'b1;
            if (pick_blocked) begin
                issue_repend[pick_idx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (go && !pick_blocked && !pick_zero) begin
            valid_q <= 1'b1;
            addr_q  <= {pick_ent.addr_hi, pick_ent.addr_lo};
            data_q  <= pick_ent.data;
        end else if (msg_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign msg_valid = valid_q;
    assign msg_addr  = addr_q;
    assign msg_data  = data_q;

endmodule

// File: rtl/msix_ctrl.sv
module msix_ctrl
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int OFF_W   = 16,
    parameter int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_wide,
    input  logic [1:0]        acc_region,
    input  logic [OFF_W-1:0]  acc_offset,
    input  logic [63:0]       acc_wdata,
    output logic [63:0]       acc_rdata,
    input  logic              trig_valid,
    input  logic [IDX_W-1:0]  trig_vec,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [63:0]       msg_addr,
    output logic [31:0]       msg_data
);

    localparam int PBA_WORDS = NUM_VEC / PBA_BITS + 1;
    localparam int PBA_FLAT  = PBA_WORDS * PBA_BITS;

    region_e               rg;
    logic                  aligned;
    logic [OFF_W-5:0]      tbl_idx;
    logic [OFF_W-4:0]      pba_word;
    logic                  tbl_hit;
    logic                  pba_hit;
    logic                  ctrl_hit;
    vec_entry_t            sel_entry;
    logic                  sel_ok;
    logic [63:0]           pba_sel;
    logic                  pba_ok;
    logic [PBA_FLAT-1:0]   pba_flat;

    logic                  en_q;
    logic                  fm_q;

    vec_entry_t            entries [NUM_VEC];
    logic [NUM_VEC-1:0]    vmask;
    logic [NUM_VEC-1:0]    trig_hit;
    logic [NUM_VEC-1:0]    req_q;
    logic [NUM_VEC-1:0]    pend_q;
    logic [NUM_VEC-1:0]    issue_clr;
    logic [NUM_VEC-1:0]    issue_repend;

    assign rg       = region_e'(acc_region);
    assign aligned  = access_aligned(acc_wide, acc_offset[2:0]);
    assign tbl_idx  = acc_offset[OFF_W-1:4];
    assign pba_word = acc_offset[OFF_W-1:3];
    assign pba_flat = {{(PBA_FLAT - NUM_VEC){1'b0}}, pend_q};

    always_comb begin
        sel_entry = '0;
        sel_ok    = 1'b0;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (int'(tbl_idx) == v) begin
                sel_entry = entries[v];
                sel_ok    = 1'b1;
            end
        end
    end

    always_comb begin
        pba_sel = '0;
        pba_ok  = 1'b0;
        for (int w = 0; w < PBA_WORDS; w++) begin
            if (int'(pba_word) == w) begin
                pba_sel = pba_flat[w*PBA_BITS +: PBA_BITS];
                pba_ok  = 1'b1;
            end
        end
    end

    assign tbl_hit  = (rg == RG_TABLE) && aligned && sel_ok;
    assign pba_hit  = (rg == RG_PBA) && aligned && pba_ok;
    assign ctrl_hit = (rg == RG_CTRL) && !acc_wide && (acc_offset == '0);

    // Message control: only enable and function mask are writable.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            fm_q <= 1'b0;
        end else if (acc_valid && acc_write && ctrl_hit) begin
            en_q <= acc_wdata[15];
            fm_q <= acc_wdata[14];
        end
    end

    always_comb begin
        acc_rdata = '0;
        if (acc_valid && !acc_write) begin
            case (rg)
                RG_TABLE: if (tbl_hit) acc_rdata = entry_read(sel_entry, acc_wide, acc_offset[3:2]);
                RG_PBA: begin
                    if (pba_hit) begin
                        if (acc_wide)           acc_rdata = pba_sel;
                        else if (acc_offset[2]) acc_rdata = {32'b0, pba_sel[63:32]};
                        else                    acc_rdata = {32'b0, pba_sel[31:0]};
                    end
                end
                RG_CTRL: if (ctrl_hit) acc_rdata = {48'b0, en_q, fm_q, 3'b0, 11'(NUM_VEC - 1)};
                default: acc_rdata = '0;
            endcase
        end
    end

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_trig
        assign trig_hit[v] = trig_valid && (trig_vec == IDX_W'(v));
    end

    msix_vec_store #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (acc_valid && acc_write && tbl_hit),
        .wr_idx  (tbl_idx[IDX_W-1:0]),
        .wr_wide (acc_wide),
        .wr_dw   (acc_offset[3:2]),
        .wr_data (acc_wdata),
        .entries (entries),
        .vmask   (vmask)
    );

    msix_pend_ctrl #(.NUM_VEC(NUM_VEC)) u_pend (
        .clk          (clk),
        .rst          (rst),
        .enable       (en_q),
        .fmask        (fm_q),
        .vmask        (vmask),
        .trig_hit     (trig_hit),
        .issue_clr    (issue_clr),
        .issue_repend (issue_repend),
        .req_q        (req_q),
        .pend_q       (pend_q)
    );

    msix_issue #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_issue (
        .clk          (clk),
        .rst          (rst),
        .enable       (en_q),
        .fmask        (fm_q),
        .req_q        (req_q),
        .entries      (entries),
        .issue_clr    (issue_clr),
        .issue_repend (issue_repend),
        .msg_valid    (msg_valid),
        .msg_ready    (msg_ready),
        .msg_addr     (msg_addr),
        .msg_data     (msg_data)
    );

endmodule

// File: rtl/msix_ctrl_chk.sv
module msix_ctrl_chk #(
    parameter int NUM_VEC = 8,
    parameter int OFF_W   = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               en_q,
    input logic [NUM_VEC-1:0] pend_q,
    input logic               acc_valid,
    input logic               acc_write,
    input logic [OFF_W-1:0]   acc_offset,
    input logic [63:0]        acc_rdata,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [63:0]        msg_addr,
    input logic [31:0]        msg_data
);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!msg_valid && (pend_q == '0) && !en_q)); // R1

    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R14

    AST_NONZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_addr != 64'd0)); // R12

    AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (rst)
        (!msg_valid && !en_q) |=> !msg_valid); // R13

    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && (acc_offset[1:0] != 2'b00)) |-> (acc_rdata == 64'd0)); // R11

endmodule

bind msix_ctrl msix_ctrl_chk #(.NUM_VEC(NUM_VEC), .OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_q       (en_q),
    .pend_q     (pend_q),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_offset (acc_offset),
    .acc_rdata  (acc_rdata),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_addr   (msg_addr),
    .msg_data   (msg_data)
);

// File: tb/msix_ctrl_test.sv
module msix_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_VEC    = 8;
    localparam int OFF_W      = 16;
    localparam int IDX_W      = 3;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              acc_valid = 1'b0;
    logic              acc_write = 1'b0;
    logic              acc_wide = 1'b0;
    logic [1:0]        acc_region = 2'd0;
    logic [OFF_W-1:0]  acc_offset = '0;
    logic [63:0]       acc_wdata = '0;
    logic [63:0]       acc_rdata;
    logic              trig_valid = 1'b0;
    logic [IDX_W-1:0]  trig_vec = '0;
    logic              msg_valid;
    logic              msg_ready = 1'b1;
    logic [63:0]       msg_addr;
    logic [31:0]       msg_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int          log_n = 0;
    logic [63:0] log_addr [64];
    logic [31:0] log_data [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    msix_ctrl #(.NUM_VEC(NUM_VEC), .OFF_W(OFF_W), .IDX_W(IDX_W)) uut (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_wide(acc_wide),
        .acc_region(acc_region), .acc_offset(acc_offset), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata),
        .trig_valid(trig_valid), .trig_vec(trig_vec),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    // Record every accepted message.
    always @(posedge clk) begin
        if (!rst && msg_valid && msg_ready && log_n < 64) begin
            log_addr[log_n] = msg_addr;
            log_data[log_n] = msg_data;
            log_n = log_n + 1;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] rg, input int off, input logic wide, input logic [63:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_wide = wide;
        acc_region = rg; acc_offset = OFF_W'(off); acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] rg, input int off, input logic wide, output logic [63:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_wide = wide;
        acc_region = rg; acc_offset = OFF_W'(off);
        #1;
        d = acc_rdata;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic trig(input int v);
        @(negedge clk);
        trig_valid = 1'b1; trig_vec = IDX_W'(v);
        @(negedge clk);
        trig_valid = 1'b0;
    endtask

    task automatic set_mask(input int v, input logic m);
        wr(2'd0, 16*v + 12, 1'b0, {63'b0, m});
    endtask

    task automatic t_reset();
        logic [63:0] d;
        check("R1 msg_valid after reset", {63'b0, msg_valid}, 64'd0);
        rd(2'd2, 0, 1'b0, d);
        check("R1 R5 control word after reset", d, 64'h7);
        rd(2'd1, 0, 1'b1, d);
        check("R1 pending array after reset", d, 64'd0);
        rd(2'd0, 16*3, 1'b1, d);
        check("R1 entry 3 address after reset", d, 64'd0);
    endtask

    task automatic t_table();
        logic [63:0] d;
        wr(2'd0, 32, 1'b0, 64'h1111_2220);
        wr(2'd0, 36, 1'b0, 64'hAAAA_0001);
        wr(2'd0, 40, 1'b0, 64'hD002);
        wr(2'd0, 44, 1'b0, 64'hFFFF_FFFF);
        rd(2'd0, 32, 1'b0, d); check("R2 address low dword", d, 64'h1111_2220);
        rd(2'd0, 36, 1'b0, d); check("R2 address high dword", d, 64'hAAAA_0001);
        rd(2'd0, 40, 1'b0, d); check("R2 data dword", d, 64'hD002);
        rd(2'd0, 44, 1'b0, d); check("R4 reserved control bits read zero", d, 64'h1);
        rd(2'd0, 32, 1'b1, d); check("R3 64-bit address read", d, 64'hAAAA_0001_1111_2220);
        rd(2'd0, 40, 1'b1, d); check("R3 64-bit data/control read", d, 64'h0000_0001_0000_D002);
        wr(2'd0, 64, 1'b1, 64'h0000_0002_3333_4440);
        rd(2'd0, 68, 1'b0, d); check("R3 64-bit write high half", d, 64'h2);
        wr(2'd0, 72, 1'b1, 64'h0000_0001_0000_D004);
        rd(2'd0, 76, 1'b0, d); check("R3 64-bit write control half", d, 64'h1);
    endtask

    task automatic t_ctrl();
        logic [63:0] d;
        wr(2'd2, 0, 1'b0, 64'hFFFF_FFFF);
        rd(2'd2, 0, 1'b0, d); check("R5 only enable/mask writable", d, 64'hC007);
        wr(2'd2, 0, 1'b0, 64'h0);
        rd(2'd2, 0, 1'b0, d); check("R5 bits cleared, size kept", d, 64'h7);
    endtask

    task automatic t_reject();
        logic [63:0] d;
        wr(2'd0, 33, 1'b0, 64'hDEAD_BEEF);
        rd(2'd0, 32, 1'b0, d); check("R11 misaligned write ignored", d, 64'h1111_2220);
        rd(2'd0, 34, 1'b0, d); check("R11 misaligned read zero", d, 64'd0);
        rd(2'd0, 36, 1'b1, d); check("R11 misaligned 64-bit read zero", d, 64'd0);
        rd(2'd2, 0, 1'b1, d); check("R11 64-bit control read zero", d, 64'd0);
        rd(2'd3, 0, 1'b0, d); check("R11 unused region read zero", d, 64'd0);
        wr(2'd0, 16*NUM_VEC, 1'b0, 64'h55);
        rd(2'd0, 16*NUM_VEC, 1'b0, d); check("R11 out-of-range entry read zero", d, 64'd0);
        rd(2'd1, 8, 1'b0, d); check("R11 out-of-range pending word zero", d, 64'd0);
        wr(2'd2, 0, 1'b1, 64'h8000);
        rd(2'd2, 0, 1'b0, d); check("R11 64-bit control write ignored", d, 64'h7);
    endtask

    task automatic setup_all();
        for (int v = 0; v < NUM_VEC; v++) begin
            wr(2'd0, 16*v,     1'b0, 64'(32'h1000 + 16*v));
            wr(2'd0, 16*v + 4, 1'b0, 64'd0);
            wr(2'd0, 16*v + 8, 1'b0, 64'(32'hD000 + v));
            set_mask(v, 1'b0);
        end
        wr(2'd2, 0, 1'b0, 64'h8000);
    endtask

    task automatic t_fire();
        int base;
        base = log_n;
        trig(3);
        idle(6);
        check("R6 one message", 64'(log_n - base), 64'd1);
        check("R6 message address", log_addr[base], 64'h1030);
        check("R6 message data", 64'(log_data[base]), 64'hD003);
    endtask

    task automatic t_vec_mask();
        logic [63:0] d;
        int base;
        base = log_n;
        set_mask(5, 1'b1);
        trig(5);
        idle(6);
        check("R7 vector-masked trigger sends nothing", 64'(log_n - base), 64'd0);
        rd(2'd1, 0, 1'b0, d); check("R7 R10 pending bit 5 set", d, 64'h20);
        set_mask(5, 1'b0);
        idle(6);
        check("R8 unmask replays", 64'(log_n - base), 64'd1);
        check("R8 replayed data", 64'(log_data[base]), 64'hD005);
        rd(2'd1, 0, 1'b0, d); check("R8 pending bit cleared", d, 64'd0);
    endtask

    task automatic t_fmask();
        logic [63:0] d;
        logic [31:0] first;
        int base;
        base = log_n;
        wr(2'd2, 0, 1'b0, 64'hC000);
        set_mask(6, 1'b1);
        trig(6); trig(2); trig(5);
        idle(4);
        check("R7 function-masked triggers send nothing", 64'(log_n - base), 64'd0);
        rd(2'd1, 0, 1'b0, d); check("R7 pending bits 2,5,6", d, 64'h64);
        @(negedge clk); msg_ready = 1'b0;
        wr(2'd2, 0, 1'b0, 64'h8000);
        idle(3);
        check("R14 valid under backpressure", {63'b0, msg_valid}, 64'd1);
        first = msg_data;
        idle(4);
        check("R14 data held under backpressure", 64'(msg_data), 64'(first));
        check("R9 lowest index presented first", 64'(first), 64'hD002);
        rd(2'd1, 0, 1'b0, d); check("R9 unmasked pending cleared, masked kept", d, 64'h40);
        @(negedge clk); msg_ready = 1'b1;
        idle(6);
        check("R9 two replays", 64'(log_n - base), 64'd2);
        check("R9 first replay vector 2", 64'(log_data[base]), 64'hD002);
        check("R9 second replay vector 5", 64'(log_data[base+1]), 64'hD005);
        set_mask(6, 1'b0);
        idle(6);
        check("R8 vector 6 replay after its own unmask", 64'(log_data[base+2]), 64'hD006);
    endtask

    task automatic t_pba();
        logic [63:0] d;
        int base;
        base = log_n;
        wr(2'd2, 0, 1'b0, 64'hC000);
        trig(7); trig(0);
        rd(2'd1, 0, 1'b0, d); check("R10 32-bit low half", d, 64'h81);
        rd(2'd1, 4, 1'b0, d); check("R10 32-bit high half", d, 64'h0);
        rd(2'd1, 0, 1'b1, d); check("R10 64-bit word", d, 64'h81);
        wr(2'd1, 0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(2'd1, 0, 1'b0, 64'h0);
        rd(2'd1, 0, 1'b1, d); check("R10 pending writes ignored", d, 64'h81);
        wr(2'd2, 0, 1'b0, 64'h8000);
        idle(6);
        check("R9 two drained", 64'(log_n - base), 64'd2);
        check("R9 vector 0 first", 64'(log_data[base]), 64'hD000);
        check("R9 vector 7 second", 64'(log_data[base+1]), 64'hD007);
    endtask

    task automatic t_zero();
        logic [63:0] d;
        int base;
        base = log_n;
        wr(2'd0, 16, 1'b1, 64'd0);
        trig(1);
        idle(6);
        check("R12 zero address sends nothing", 64'(log_n - base), 64'd0);
        rd(2'd1, 0, 1'b0, d); check("R12 no pending left", d, 64'd0);
        trig(3);
        idle(6);
        check("R12 later vector still sends", 64'(log_n - base), 64'd1);
    endtask

    task automatic t_disabled();
        logic [63:0] d;
        int base;
        base = log_n;
        wr(2'd2, 0, 1'b0, 64'h0);
        trig(3);
        idle(6);
        check("R13 disabled trigger sends nothing", 64'(log_n - base), 64'd0);
        wr(2'd2, 0, 1'b0, 64'h4000);
        trig(4);
        rd(2'd1, 0, 1'b0, d); check("R13 disabled masked trigger leaves no pending", d, 64'd0);
        wr(2'd2, 0, 1'b0, 64'h8000);
        idle(6);
        check("R13 nothing replayed on enable", 64'(log_n - base), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_table();
        t_ctrl();
        t_reject();
        setup_all();
        t_fire();
        t_vec_mask();
        t_fmask();
        t_pba();
        t_zero();
        t_disabled();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule